// File: doc/BRIEF.md
# Multi-Mode Logic Analyzer Trigger

This block decides the moment a logic analyzer capture starts. It watches a bank of sampled data pins plus a few external trigger pins. Every pin has five separately enabled conditions: any edge, rising edge, falling edge, low level and high level. The matches from all pins are merged into one logic trigger, either by OR or by AND. That logic trigger is then mixed with a trigger coming from an oscilloscope path, using an operator chosen in configuration.

A hold-off counter stops a burst of events from retriggering the capture. A sticky status flag records that a trigger fired and is cleared by writing 1 to it. Configuration goes through a simple register-style write port with a combinational read-back. Bus decoding is left to the surrounding logic.

Top module: `la_trigger_core`

## Requirements
- R1: Each pin has five condition enables, held in separate masks at config addresses 0 (any edge), 1 (rising), 2 (falling), 3 (low level) and 4 (high level). In each mask, bits [DATA_PINS-1:0] belong to the data pins and the next EXT_PINS bits belong to the external pins, in index order. A pin matches when any of its enabled conditions holds.
- R2: Pins are evaluated only in cycles with `smp_valid` high. An edge compares the current sample with the last valid sample, which reads as 0 after reset. Cycles without valid neither match nor update that previous sample.
- R3: Bit 0 of config address 5 selects how pin matches combine: 0 gives OR over all pins, 1 gives AND over the pins that have at least one enabled condition. With no condition enabled, the logic trigger stays low in both modes.
- R4: Bits [6:4] of config address 5 choose the final trigger: 0 gives the logic trigger, 1 the oscilloscope trigger, 2 their AND, 3 their OR and 4 their XOR. The oscilloscope trigger is taken in every cycle, whether or not a sample is valid.
- R5: Final-select codes 5, 6 and 7 never produce a trigger.
- R6: Config address 6 holds a hold-off count H. After each trigger pulse, events in the next H cycles are ignored, so a continuous event fires every H+1 cycles. H=0 allows a trigger in every cycle.
- R7: Bit 0 of config address 7 is a status flag. It sets in the cycle `trig_out` pulses and stays set until a write with bit 0 set to address 7 clears it. A trigger in the same cycle as a clear wins.
- R8: `trig_out` is registered: it goes high in the cycle after the one whose inputs met the condition. After reset every register, `trig_out` and the flag are 0.
- R9: Addresses 0 to 6 read back the written value, truncated to the field width and zero-extended to CFG_W. Address 5 reads back the combine bit at bit 0 and the select at bits [6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Pin sample valid |
| pin_data | input | DATA_PINS | Sampled data pins |
| ext_pins | input | EXT_PINS | Sampled external trigger pins |
| scope_trig | input | 1 | Trigger from the oscilloscope path |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Configuration read data (combinational) |
| trig_out | output | 1 | Registered trigger pulse |
| flag_o | output | 1 | Sticky triggered status |

## Verification
The bench builds the block with DATA_PINS=4, EXT_PINS=2 and HOLD_W=8. With these values the external pins sit at mask bits 4 and 5, so a mistake in where their bits are placed shows up right away. A hold-off write wider than 8 bits exposes the truncation on read-back. A short hold-off of 3 cycles lets the bench check the whole retrigger pattern in a few clocks. All eight final-select codes are run against every combination of logic and oscilloscope trigger.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;
   localparam int CFG_AW = 3;

   localparam logic [CFG_AW-1:0] ADR_ANY  = 3'd0;
   localparam logic [CFG_AW-1:0] ADR_RISE = 3'd1;
   localparam logic [CFG_AW-1:0] ADR_FALL = 3'd2;
   localparam logic [CFG_AW-1:0] ADR_LOW  = 3'd3;
   localparam logic [CFG_AW-1:0] ADR_HIGH = 3'd4;
   localparam logic [CFG_AW-1:0] ADR_MIX  = 3'd5;
   localparam logic [CFG_AW-1:0] ADR_HOLD = 3'd6;
   localparam logic [CFG_AW-1:0] ADR_STAT = 3'd7;

   // final trigger operator; codes 5 and 6 are unnamed and act as off
   typedef enum logic [2:0] {
      MIX_LOGIC  = 3'd0,
      MIX_SCOPE  = 3'd1,
      MIX_BOTH   = 3'd2,
      MIX_EITHER = 3'd3,
      MIX_DIFFER = 3'd4,
      MIX_OFF    = 3'd7
   } mix_sel_e;
endpackage

// File: rtl/la_trig_regs.sv
module la_trig_regs
   import la_trig_pkg::*;
#(
   parameter int NPINS  = 18,
   parameter int CFG_W  = 32,
   parameter int HOLD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              fire,
   output logic [NPINS-1:0]  m_any,
   output logic [NPINS-1:0]  m_rise,
   output logic [NPINS-1:0]  m_fall,
   output logic [NPINS-1:0]  m_low,
   output logic [NPINS-1:0]  m_high,
   output logic              and_mode,
   output logic [2:0]        mix_sel,
   output logic [HOLD_W-1:0] hold_val,
   output logic              flag,
   output logic [CFG_W-1:0]  cfg_rdata
);
   logic clr_req;
   assign clr_req = cfg_we && (cfg_addr == ADR_STAT) && cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_any    <= '0;
         m_rise   <= '0;
         m_fall   <= '0;
         m_low    <= '0;
         m_high   <= '0;
         and_mode <= 1'b0;
         mix_sel  <= 3'd0;
         hold_val <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            ADR_ANY:  m_any    <= cfg_wdata[NPINS-1:0];
            ADR_RISE: m_rise   <= cfg_wdata[NPINS-1:0];
            ADR_FALL: m_fall   <= cfg_wdata[NPINS-1:0];
            ADR_LOW:  m_low    <= cfg_wdata[NPINS-1:0];
            ADR_HIGH: m_high   <= cfg_wdata[NPINS-1:0];
            ADR_MIX: begin
               and_mode <= cfg_wdata[0];
               mix_sel  <= cfg_wdata[6:4];
            end
            ADR_HOLD: hold_val <= cfg_wdata[HOLD_W-1:0];
            default: ;
         endcase
      end
   end

   // a new trigger outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (fire)    flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         ADR_ANY:  cfg_rdata[NPINS-1:0]  = m_any;
         ADR_RISE: cfg_rdata[NPINS-1:0]  = m_rise;
         ADR_FALL: cfg_rdata[NPINS-1:0]  = m_fall;
         ADR_LOW:  cfg_rdata[NPINS-1:0]  = m_low;
         ADR_HIGH: cfg_rdata[NPINS-1:0]  = m_high;
         ADR_MIX: begin
            cfg_rdata[0]   = and_mode;
            cfg_rdata[6:4] = mix_sel;
         end
         ADR_HOLD: cfg_rdata[HOLD_W-1:0] = hold_val;
         default:  cfg_rdata[0]          = flag;
      endcase
   end
endmodule

// File: rtl/la_pin_match.sv
module la_pin_match #(
   parameter int NPINS = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [NPINS-1:0] pins,
   input  logic [NPINS-1:0] m_any,
   input  logic [NPINS-1:0] m_rise,
   input  logic [NPINS-1:0] m_fall,
   input  logic [NPINS-1:0] m_low,
   input  logic [NPINS-1:0] m_high,
   output logic [NPINS-1:0] hit,
   output logic [NPINS-1:0] armed
);
   logic [NPINS-1:0] prev_q;

   // previous sample advances only on valid samples
   always_ff @(posedge clk) begin
      if (!rst_n)         prev_q <= '0;
      else if (smp_valid) prev_q <= pins;
   end

   for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
      logic rose, fell, cond;
      assign rose = pins[gi] & ~prev_q[gi];
      assign fell = ~pins[gi] & prev_q[gi];
      assign cond = (m_any[gi]  & (rose | fell))
                  | (m_rise[gi] & rose)
                  | (m_fall[gi] & fell)
                  | (m_low[gi]  & ~pins[gi])
                  | (m_high[gi] & pins[gi]);
      assign armed[gi] = m_any[gi] | m_rise[gi] | m_fall[gi] | m_low[gi] | m_high[gi];
      assign hit[gi]   = smp_valid & cond;
   end
endmodule

// File: rtl/la_trig_mix.sv
module la_trig_mix
   import la_trig_pkg::*;
#(
   parameter int NPINS = 18
) (
   input  logic [NPINS-1:0] hit,
   input  logic [NPINS-1:0] armed,
   input  logic             and_mode,
   input  logic [2:0]       mix_sel,
   input  logic             scope_trig,
   output logic             event_o
);
   logic logic_trig;

   always_comb begin
      if (and_mode) logic_trig = (|armed) && (&(hit | ~armed));
      else          logic_trig = |hit;
   end

   always_comb begin
      case (mix_sel)
         MIX_LOGIC:  event_o = logic_trig;
         MIX_SCOPE:  event_o = scope_trig;
         MIX_BOTH:   event_o = logic_trig & scope_trig;
         MIX_EITHER: event_o = logic_trig | scope_trig;
         MIX_DIFFER: event_o = logic_trig ^ scope_trig;
         default:    event_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/la_holdoff.sv
module la_holdoff #(
   parameter int HOLD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              event_i,
   input  logic [HOLD_W-1:0] hold_val,
   output logic              fire,
   output logic              trig_q
);
   logic [HOLD_W-1:0] cnt_q;

   assign fire = event_i && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= fire;
         if (fire)               cnt_q <= hold_val;
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/la_trigger_core.sv
module la_trigger_core
   import la_trig_pkg::*;
#(
   parameter int DATA_PINS = 16,
   parameter int EXT_PINS  = 2,
   parameter int HOLD_W    = 32,
   parameter int CFG_W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic [DATA_PINS-1:0] pin_data,
   input  logic [EXT_PINS-1:0]  ext_pins,
   input  logic                 scope_trig,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   output logic                 trig_out,
   output logic                 flag_o
);
   localparam int NPINS = DATA_PINS + EXT_PINS;

   if (DATA_PINS < 1 || EXT_PINS < 1) begin : g_bad_pins
      $error("la_trigger_core: pin counts must be at least 1");
   end
   if (CFG_W < 7 || NPINS > CFG_W) begin : g_bad_cfg
      $error("la_trigger_core: CFG_W must hold the select field and every mask");
   end
   if (HOLD_W < 1 || HOLD_W > CFG_W) begin : g_bad_hold
      $error("la_trigger_core: HOLD_W out of range");
   end

   logic [NPINS-1:0]  pins, hit, armed;
   logic [NPINS-1:0]  m_any, m_rise, m_fall, m_low, m_high;
   logic              and_mode, evt, fire;
   logic [2:0]        mix_sel;
   logic [HOLD_W-1:0] hold_val;

   assign pins = {ext_pins, pin_data};

   la_trig_regs #(.NPINS(NPINS), .CFG_W(CFG_W), .HOLD_W(HOLD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .fire(fire), .m_any(m_any), .m_rise(m_rise),
      .m_fall(m_fall), .m_low(m_low), .m_high(m_high), .and_mode(and_mode),
      .mix_sel(mix_sel), .hold_val(hold_val), .flag(flag_o), .cfg_rdata(cfg_rdata)
   );

   la_pin_match #(.NPINS(NPINS)) u_match (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .pins(pins),
      .m_any(m_any), .m_rise(m_rise), .m_fall(m_fall), .m_low(m_low),
      .m_high(m_high), .hit(hit), .armed(armed)
   );

   la_trig_mix #(.NPINS(NPINS)) u_mix (
      .hit(hit), .armed(armed), .and_mode(and_mode), .mix_sel(mix_sel),
      .scope_trig(scope_trig), .event_o(evt)
   );

   la_holdoff #(.HOLD_W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .event_i(evt), .hold_val(hold_val),
      .fire(fire), .trig_q(trig_out)
   );
endmodule

// File: rtl/la_trigger_chk.sv
module la_trigger_chk
   import la_trig_pkg::*;
#(
   parameter int HOLD_W = 32,
   parameter int CFG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [CFG_W-1:0]  cfg_wdata,
   input logic [2:0]        mix_sel,
   input logic [HOLD_W-1:0] hold_val,
   input logic              trig_out,
   input logic              flag_o
);
   logic clr_wr;
   assign clr_wr = cfg_we && (cfg_addr == ADR_STAT) && cfg_wdata[0];

   p_logic_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_sel == 3'd0 && !smp_valid) |=> !trig_out);

   p_off_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_sel >= 3'd5) |=> !trig_out);

   p_holdoff_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_out && $past(hold_val) != '0) |=> !trig_out);

   p_flag_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> flag_o);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_wr) |=> flag_o);

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && clr_wr) |=> (!flag_o || trig_out));
endmodule

bind la_trigger_core la_trigger_chk #(.HOLD_W(HOLD_W), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cfg_we(cfg_we),
   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mix_sel(mix_sel),
   .hold_val(hold_val), .trig_out(trig_out), .flag_o(flag_o)
);

// File: tb/sim_la_trigger_core.sv
module sim_la_trigger_core;
   localparam int DP = 4;
   localparam int EP = 2;
   localparam int HW = 8;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DP-1:0] pin_data = '0;
   logic [EP-1:0] ext_pins = '0;
   logic          scope_trig = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [CW-1:0] cfg_wdata = '0;
   logic [CW-1:0] cfg_rdata;
   logic          trig_out, flag_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   la_trigger_core #(.DATA_PINS(DP), .EXT_PINS(EP), .HOLD_W(HW), .CFG_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .pin_data(pin_data),
      .ext_pins(ext_pins), .scope_trig(scope_trig), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .trig_out(trig_out), .flag_o(flag_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      cfg_addr = a;
      #1;
      v = cfg_rdata;
   endtask

   // drive one cycle of inputs; on return trig_out reflects them
   task automatic smp(input logic [DP-1:0] d, input logic [EP-1:0] e,
                      input logic v, input logic s);
      pin_data = d; ext_pins = e; smp_valid = v; scope_trig = s;
      @(negedge clk);
      smp_valid = 1'b0; scope_trig = 1'b0;
   endtask

   task automatic clear_cfg();
      for (int a = 0; a < 7; a++) wr(a[2:0], 32'd0);
      wr(3'd7, 32'd1);
   endtask

   function automatic logic exp_mix(input int sel, input logic l, input logic s);
      case (sel)
         0: return l;
         1: return s;
         2: return l & s;
         3: return l | s;
         4: return l ^ s;
         default: return 1'b0;
      endcase
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      chk("R8 trig_out after reset", {31'd0, trig_out}, 32'd0);
      rd(3'd7, v); chk("R8 flag after reset", v, 32'd0);
      rd(3'd0, v); chk("R8 mask after reset", v, 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R9 any mask readback", v, 32'h3F);
      wr(3'd3, 32'h0000_0015); rd(3'd3, v); chk("R9 low mask readback", v, 32'h15);
      wr(3'd6, 32'h0000_01FF); rd(3'd6, v); chk("R9 hold readback truncated", v, 32'hFF);
      wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R9 mix readback", v, 32'h71);
      clear_cfg();
   endtask

   task automatic t_rise_fall();
      wr(3'd1, 32'h02);
      smp(4'h0, 2'b00, 1'b1, 1'b0); chk("R1 rise: low pin", {31'd0, trig_out}, 32'd0);
      smp(4'h2, 2'b00, 1'b1, 1'b0); chk("R1 rise: pin1 rises", {31'd0, trig_out}, 32'd1);
      smp(4'h2, 2'b00, 1'b1, 1'b0); chk("R1 rise: held high", {31'd0, trig_out}, 32'd0);
      smp(4'h0, 2'b00, 1'b1, 1'b0); chk("R1 rise: falling ignored", {31'd0, trig_out}, 32'd0);
      clear_cfg();
      // ext pin 1 lives at mask bit DP+1
      wr(3'd2, 32'h20);
      smp(4'h0, 2'b10, 1'b1, 1'b0); chk("R1 ext fall: ext high", {31'd0, trig_out}, 32'd0);
      smp(4'h0, 2'b00, 1'b1, 1'b0); chk("R1 ext fall: ext1 falls", {31'd0, trig_out}, 32'd1);
      smp(4'h0, 2'b01, 1'b1, 1'b0); chk("R1 ext fall: other ext pin", {31'd0, trig_out}, 32'd0);
      clear_cfg();
      wr(3'd0, 32'h08);
      smp(4'h0, 2'b00, 1'b1, 1'b0);
      smp(4'h8, 2'b00, 1'b1, 1'b0); chk("R1 any edge up", {31'd0, trig_out}, 32'd1);
      smp(4'h0, 2'b00, 1'b1, 1'b0); chk("R1 any edge down", {31'd0, trig_out}, 32'd1);
      smp(4'h0, 2'b00, 1'b1, 1'b0); chk("R1 any edge steady", {31'd0, trig_out}, 32'd0);
      clear_cfg();
   endtask

   task automatic t_valid_gap();
      wr(3'd1, 32'h01);
      smp(4'h0, 2'b00, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         smp(4'h1, 2'b00, 1'b0, 1'b0); chk("R2 no valid, no trigger", {31'd0, trig_out}, 32'd0);
      end
      smp(4'h1, 2'b00, 1'b1, 1'b0); chk("R2 rise seen on valid", {31'd0, trig_out}, 32'd1);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      smp(4'h1, 2'b00, 1'b1, 1'b0); chk("R2 invalid low not remembered", {31'd0, trig_out}, 32'd0);
      clear_cfg();
   endtask

   task automatic t_combine();
      wr(3'd4, 32'h01);
      wr(3'd3, 32'h04);
      wr(3'd5, 32'h01);
      smp(4'h1, 2'b00, 1'b1, 1'b0); chk("R3 AND both match", {31'd0, trig_out}, 32'd1);
      smp(4'h5, 2'b00, 1'b1, 1'b0); chk("R3 AND one fails", {31'd0, trig_out}, 32'd0);
      wr(3'd5, 32'h00);
      smp(4'h5, 2'b00, 1'b1, 1'b0); chk("R3 OR one matches", {31'd0, trig_out}, 32'd1);
      smp(4'h4, 2'b00, 1'b1, 1'b0); chk("R3 OR none match", {31'd0, trig_out}, 32'd0);
      clear_cfg();
      wr(3'd5, 32'h01);
      smp(4'hF, 2'b11, 1'b1, 1'b0); chk("R3 AND with nothing enabled", {31'd0, trig_out}, 32'd0);
      wr(3'd5, 32'h00);
      smp(4'hF, 2'b11, 1'b1, 1'b0); chk("R3 OR with nothing enabled", {31'd0, trig_out}, 32'd0);
      clear_cfg();
   endtask

   task automatic t_mix();
      wr(3'd4, 32'h01);
      for (int sel = 0; sel < 8; sel++) begin
         wr(3'd5, sel << 4);
         for (int c = 0; c < 4; c++) begin
            logic l, s;
            l = c[0]; s = c[1];
            smp({3'b000, l}, 2'b00, 1'b1, s);
            if (sel >= 5)
               chk("R5 off code", {31'd0, trig_out}, 32'd0);
            else
               chk("R4 final select", {31'd0, trig_out}, {31'd0, exp_mix(sel, l, s)});
         end
      end
      wr(3'd5, 32'h10);
      smp(4'h0, 2'b00, 1'b0, 1'b1); chk("R4 scope without valid", {31'd0, trig_out}, 32'd1);
      clear_cfg();
   endtask

   task automatic t_holdoff();
      wr(3'd4, 32'h01);
      wr(3'd6, 32'd3);
      for (int i = 0; i < 9; i++) begin
         smp(4'h1, 2'b00, 1'b1, 1'b0);
         chk("R6 hold-off 3 pattern", {31'd0, trig_out}, (i % 4 == 0) ? 32'd1 : 32'd0);
      end
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      wr(3'd6, 32'd0);
      for (int i = 0; i < 3; i++) begin
         smp(4'h1, 2'b00, 1'b1, 1'b0);
         chk("R6 hold-off 0 every cycle", {31'd0, trig_out}, 32'd1);
      end
      clear_cfg();
   endtask

   task automatic t_flag();
      logic [31:0] v;
      rd(3'd7, v); chk("R7 flag cleared", v, 32'd0);
      wr(3'd5, 32'h10);
      smp(4'h0, 2'b00, 1'b0, 1'b1);
      rd(3'd7, v); chk("R7 flag set by trigger", v, 32'd1);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      smp(4'h0, 2'b00, 1'b0, 1'b0);
      rd(3'd7, v); chk("R7 flag sticky", v, 32'd1);
      wr(3'd7, 32'd0);
      rd(3'd7, v); chk("R7 write 0 keeps flag", v, 32'd1);
      wr(3'd7, 32'd1);
      rd(3'd7, v); chk("R7 write 1 clears", v, 32'd0);
      // clear and trigger in the same cycle
      cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 32'd1; scope_trig = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; scope_trig = 1'b0;
      rd(3'd7, v); chk("R7 set wins over clear", v, 32'd1);
      wr(3'd7, 32'd1);
      rd(3'd7, v); chk("R7 clear after collision", v, 32'd0);
      clear_cfg();
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_rise_fall();
      t_valid_gap();
      t_combine();
      t_mix();
      t_holdoff();
      t_flag();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule